// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the exception state of a stack-based floating-point unit. The arithmetic datapath hands it one report per operation: six exception class bits plus a separate indication that the register stack overflowed or underflowed. The reported bits accumulate into sticky flags. A stack fault bit tells a stack-caused invalid operation apart from an arithmetic one. A summary bit, derived from the flags and the six mask bits, drives the interrupt request.

Software reaches the unit through a small command port. One command loads the mask bits. Another clears the flags. A restore command reloads both masks and flags from a saved image. Three obsolete legacy opcodes, plus one spare code, are accepted and do nothing. The mask bits and the status word are always visible on output ports, so the store and save paths can read them at any time.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset, status_word is 8'h00, control_word is 6'h3F (every class masked) and irq is 0.
- R2: In the cycle after rpt_valid is 1, each bit i of rpt_excp is ORed into status bit i. The bit order is 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision. When rpt_valid is 0, rpt_excp and rpt_stack have no effect.
- R3: A report with rpt_stack=1 sets both status bit 0 (invalid) and status bit 6 (stack fault). An invalid report with rpt_stack=0 leaves bit 6 unchanged.
- R4: Flag bits 0 to 6 are sticky. Only the clear command or the restore command ever lowers one.
- R5: Status bit 7 is 1 exactly when some flag among bits 0 to 5 has its mask bit at 0. irq always equals bit 7. Unmasking a flag that is already set raises irq in the cycle the new mask takes effect.
- R6: cmd_op=1 (load masks) writes cmd_data[5:0] into the mask bits in the next cycle. control_word always shows the mask bits, in the same bit order as the flags.
- R7: cmd_op=3 (restore) loads the masks from cmd_data[5:0] and flag bits 0 to 6 from cmd_data[14:8] in the next cycle.
- R8: cmd_op=2 (clear) zeroes flag bits 0 to 6 and leaves the masks unchanged.
- R9: cmd_op values 4, 5 and 6 (the legacy opcodes), 7 (spare) and 0 (idle) change no flag and no mask.
- R10: When a report and a clear or restore fall in the same cycle, the clear or restore is applied first and the report is then ORed on top, so the reported bits survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | Exception report from the datapath is present this cycle |
| rpt_excp | input | 6 | Exception class bits of the report |
| rpt_stack | input | 1 | Report was caused by a stack overflow or underflow |
| cmd_op | input | 3 | Software command code |
| cmd_data | input | 16 | Operand of load-masks and restore commands |
| status_word | output | 8 | Flags 0 to 5, stack fault at bit 6, summary at bit 7 |
| control_word | output | 6 | Current mask bits |
| irq | output | 1 | Interrupt request, equal to the summary bit |

## Verification
A datapath report and a software clear or restore can reach the unit in the same clock, and the outcome depends on which one is applied first. The bench drives a clear together with a report, and a restore together with a stack report. It then checks that the reported bits, including the stack fault, sit on top of the cleared or restored image. After the directed cases, a randomized phase keeps reports and commands overlapping freely. A behavioural model tracks every cycle and compares the status word, the mask bits and irq.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_N      = 6;
    localparam int SF_BIT     = EXC_N;
    localparam int SUM_BIT    = EXC_N + 1;
    localparam int SW_W       = EXC_N + 2;
    localparam int OP_W       = 3;
    localparam int DATA_W     = 16;
    localparam int RST_FL_LSB = 8;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 3'd0,
        OP_LOAD_CW = 3'd1,
        OP_CLEAR   = 3'd2,
        OP_RESTORE = 3'd3,
        OP_OLD_ENA = 3'd4,
        OP_OLD_DIS = 3'd5,
        OP_OLD_PM  = 3'd6,
        OP_SPARE   = 3'd7
    } fpx_op_e;

    typedef struct packed {
        logic load_mask;
        logic clear_flags;
        logic restore;
        logic legacy;
    } fpx_act_t;
endpackage

// File: rtl/fpx_cmd_decode.sv
module fpx_cmd_decode
    import fpx_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output fpx_act_t        act
);
    always_comb begin
        act = '0;
        case (fpx_op_e'(op))
            OP_LOAD_CW: act.load_mask   = 1'b1;
            OP_CLEAR:   act.clear_flags = 1'b1;
            OP_RESTORE: act.restore     = 1'b1;
            OP_OLD_ENA,
            OP_OLD_DIS,
            OP_OLD_PM:  act.legacy      = 1'b1;
            default:    act = '0;
        endcase
    end
endmodule

// File: rtl/fpx_mask_reg.sv
module fpx_mask_reg
    import fpx_pkg::*;
#(
    parameter int N_EXC  = EXC_N,
    parameter int D_W    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fpx_act_t         act,
    input  logic [D_W-1:0]   data,
    output logic [N_EXC-1:0] mask
);
    typedef struct packed {
        logic [N_EXC-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act.load_mask || act.restore) begin
            st_d.mask = data[N_EXC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;

    // R6 / R9: masks move only under load or restore
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(act.load_mask || act.restore) |=> $stable(mask));

    // R9: legacy opcodes leave the masks alone
    a_r9_legacy_mask: assert property (@(posedge clk) disable iff (!rst_n)
        act.legacy |=> $stable(mask));
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
    import fpx_pkg::*;
#(
    parameter int N_EXC  = EXC_N,
    parameter int D_W    = DATA_W,
    parameter int FL_LSB = RST_FL_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fpx_act_t         act,
    input  logic [D_W-1:0]   data,
    input  logic             rpt_valid,
    input  logic [N_EXC-1:0] rpt_excp,
    input  logic             rpt_stack,
    output logic [N_EXC:0]   flags
);
    localparam int FL_W = N_EXC + 1;

    typedef struct packed {
        logic [FL_W-1:0] fl;
    } flag_st_t;

    flag_st_t         st_d, st_q;
    logic [FL_W-1:0]  base;
    logic [FL_W-1:0]  hit;

    always_comb begin
        if (act.clear_flags) begin
            base = '0;
        end else if (act.restore) begin
            base = data[FL_LSB +: FL_W];
        end else begin
            base = st_q.fl;
        end

        hit = '0;
        if (rpt_valid) begin
            hit[N_EXC-1:0] = rpt_excp;
            hit[0]         = rpt_excp[0] | rpt_stack;
            hit[N_EXC]     = rpt_stack;
        end

        st_d.fl = base | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.fl;

    // R4: without clear or restore no flag ever falls
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(act.clear_flags || act.restore)
        |=> ((flags & $past(flags)) == $past(flags)));

    // R3 / R10: stack report sets invalid and stack fault, whatever else happens
    a_r3_stack_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_stack) |=> (flags[0] && flags[N_EXC]));

    // R2: without report or command the flags hold
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt_valid && !act.clear_flags && !act.restore) |=> $stable(flags));

    // R8: a clear with no report leaves every flag at zero
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act.clear_flags && !rpt_valid) |=> (flags == '0));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int N_EXC  = EXC_N,
    parameter int D_W    = DATA_W,
    parameter int C_W    = OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rpt_valid,
    input  logic [N_EXC-1:0] rpt_excp,
    input  logic             rpt_stack,
    input  logic [C_W-1:0]   cmd_op,
    input  logic [D_W-1:0]   cmd_data,
    output logic [N_EXC+1:0] status_word,
    output logic [N_EXC-1:0] control_word,
    output logic             irq
);
    fpx_act_t         act;
    logic [N_EXC:0]   flags;
    logic [N_EXC-1:0] mask;
    logic             summary;

    fpx_cmd_decode u_dec (
        .op  (cmd_op),
        .act (act)
    );

    fpx_mask_reg #(.N_EXC(N_EXC), .D_W(D_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .data  (cmd_data),
        .mask  (mask)
    );

    fpx_flag_bank #(.N_EXC(N_EXC), .D_W(D_W), .FL_LSB(RST_FL_LSB)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .data      (cmd_data),
        .rpt_valid (rpt_valid),
        .rpt_excp  (rpt_excp),
        .rpt_stack (rpt_stack),
        .flags     (flags)
    );

    always_comb begin
        summary = |(flags[N_EXC-1:0] & ~mask);
    end

    assign status_word  = {summary, flags};
    assign control_word = mask;
    assign irq          = summary;

    // R5: with everything masked no interrupt can be requested
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (control_word == '1) |-> !irq);

    // R5: a flag left alone by a masking change cannot drop irq if still unmasked
    a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !act.load_mask && !act.restore && !act.clear_flags) |=> irq);
endmodule

// File: tb/fpx_status_unit_tb.sv
module fpx_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_valid = 1'b0;
    logic [5:0]  rpt_excp = '0;
    logic        rpt_stack = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_data = '0;
    logic [7:0]  status_word;
    logic [5:0]  control_word;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int ref_fl = 0;
    int ref_mk = 63;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpx_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_excp(rpt_excp),
        .rpt_stack(rpt_stack), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .status_word(status_word), .control_word(control_word), .irq(irq)
    );

    function automatic int exp_sw();
        int s = ref_fl & 127;
        if (((ref_fl & 63) & (~ref_mk & 63)) != 0) s += 128;
        return s;
    endfunction

    task automatic compare(input string tag);
        int esw = exp_sw();
        int eir = (esw >= 128) ? 1 : 0;
        checks += 3;
        if (int'(status_word) != esw) begin
            errors++;
            $display("FAIL %s status_word actual %h expected %h", tag, status_word, esw[7:0]);
        end
        if (int'(control_word) != ref_mk) begin
            errors++;
            $display("FAIL %s control_word actual %h expected %h", tag, control_word, ref_mk[5:0]);
        end
        if (int'(irq) != eir) begin
            errors++;
            $display("FAIL %s irq actual %0d expected %0d", tag, irq, eir);
        end
    endtask

    // model step: command first, then report on top
    task automatic step(input bit v, input int ex, input bit st, input int op,
                        input int dat, input string tag);
        rpt_valid = v; rpt_excp = ex[5:0]; rpt_stack = st;
        cmd_op = op[2:0]; cmd_data = dat[15:0];
        @(posedge clk);
        case (op)
            1: ref_mk = dat & 63;
            2: ref_fl = 0;
            3: begin ref_mk = dat & 63; ref_fl = (dat >> 8) & 127; end
            default: ;
        endcase
        if (v) begin
            ref_fl = ref_fl | (ex & 63);
            if (st) ref_fl = ref_fl | 1 | 64;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        step(1, 6'b000100, 0, 0, 0, "R2");
        step(0, 6'b111111, 1, 0, 0, "R2");
        step(1, 6'b100010, 0, 0, 0, "R2");
        step(1, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 2, 16'hFFFF, "R8");
        step(1, 6'b000001, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 6'h3E, "R5");
        step(0, 0, 0, 1, 6'h3F, "R6");
        step(0, 0, 0, 1, 6'h3E, "R5");
        step(0, 0, 0, 4, 16'h0000, "R9");
        step(0, 0, 0, 5, 16'h0000, "R9");
        step(0, 0, 0, 6, 16'hFFFF, "R9");
        step(0, 0, 0, 7, 16'h0000, "R9");
        step(0, 0, 0, 0, 16'h0000, "R9");
        step(0, 0, 0, 3, 16'h5A15, "R7");
        step(1, 6'b001000, 0, 2, 0, "R10");
        step(1, 0, 1, 3, 16'h0230, "R10");
        step(0, 0, 0, 2, 0, "R8");

        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 9);
            int op = (r < 6) ? 0 : $urandom_range(1, 7);
            step(($urandom_range(0, 2) == 0), $urandom_range(0, 63),
                 ($urandom_range(0, 7) == 0), op, $urandom_range(0, 65535), "R4");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule